// File: doc/BRIEF.md
# Coherence Probe Filter Home Controller

This block is the home-side coherence engine that sits next to a memory controller. It keeps a directory, held in a small SRAM-style array looked up at the home, that records for each tracked line which caching agents hold a copy, which agent owns it and in which of seven line states (M, D, O, E, F, S, I) the owner holds it. The D state marks dirty data that migrates from cache to cache instead of being replicated. For every fill request from a requesting core cluster, the controller reads the directory and chooses the cheapest probe flow that keeps caches coherent. That flow is one of four: no probe, a directed probe to one holder, a multicast probe to the known holders, or a broadcast to every other agent. Probe targets are the caching clusters.

The memory read is always issued, and the home probes the targets with one message carrying a target mask. It counts the responses it expects from that mask. When every response and the memory data have arrived, it releases one completion to the requester. Dirty data returned by any target replaces the memory data. A directory slot that holds a different line is first emptied by an invalidation probe to that line's holders. Transactions are handled one at a time, so a later request, including one to the same line, waits until the current completion is accepted.

All data channels are valid/ready. A source holds its valid and payload stable until ready is seen at a clock edge. The probe, memory-read and completion outputs follow that rule under back-pressure. The home raises `rsp_ready` only while responses are still owed. It raises `mem_rsp_ready` only while its single memory beat is outstanding.

Top module: `pf_home`

## Requirements
- R1: After reset `req_ready` is 1 and `prb_valid`, `mem_rd_valid` and `cpl_valid` are 0.
- R2: A request to a line with no holder other than the requester sends no probe; its completion has `cpl_flow` = 0 (none) and carries the memory data.
- R3: With exactly one other holder, one probe goes out with that single agent's bit set in `prb_mask` and `prb_flow` = 1 (directed).
- R4: With two to MCAST_MAX other holders, `prb_mask` is exactly those holders and `prb_flow` = 2 (multicast).
- R5: With more than MCAST_MAX other holders, `prb_mask` is every agent except the requester and `prb_flow` = 3 (broadcast).
- R6: `prb_inval` is 1 for an exclusive request and for a shared read of a line in state D; otherwise the probe asks holders to keep a shared copy (`prb_inval` = 0).
- R7: Exactly one completion is produced, and only after as many probe responses as bits set in the probe mask, plus the memory data, have been accepted.
- R8: If any probe response has `rsp_dirty` = 1, the completion carries that response's data instead of memory data; clean response data is ignored.
- R9: Granted state codes are I=0, S=1, F=2, E=3, O=4, D=5, M=6. A shared read gets E on an untracked line, S on a line in M or O (which is left in O at its owner), and F on a line in E, F or S (the requester becomes the forwarder). An exclusive request gets D if the line was dirty (M, O, D), else M.
- R10: A shared read of a D line migrates it: the old holders are invalidated, the requester gets D, and the next request to that line probes only that requester.
- R11: A request whose directory slot (index = low address bits) holds another valid line first sends an invalidation probe to that line's holders at that line's address. That probe is broadcast to all agents if they number more than MCAST_MAX. The request then proceeds as if its line were untracked.
- R12: `req_ready` is 0 from the cycle after a request is accepted until its completion is accepted.
- R13: While `prb_valid` or `cpl_valid` is 1 and its ready is 0, the valid and the payload stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request valid |
| req_ready | output | 1 | Home can take a request |
| req_addr | input | AW | Line address of the request |
| req_agent | input | log2(NA) | Requesting agent id |
| req_excl | input | 1 | 1 = exclusive (write) request, 0 = shared read |
| prb_valid | output | 1 | Probe valid |
| prb_ready | input | 1 | Fabric takes the probe |
| prb_addr | output | AW | Probed line address |
| prb_mask | output | NA | Target agents of the probe |
| prb_inval | output | 1 | 1 = invalidate, 0 = downgrade to shared |
| prb_flow | output | 2 | 1 directed, 2 multicast, 3 broadcast |
| rsp_valid | input | 1 | Probe response valid |
| rsp_ready | output | 1 | Home still expects responses |
| rsp_dirty | input | 1 | Response carries dirty data |
| rsp_data | input | DW | Response data |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory data valid |
| mem_rsp_ready | output | 1 | Home awaits its memory beat |
| mem_rsp_data | input | DW | Memory data |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Requester takes the completion |
| cpl_agent | output | log2(NA) | Requester id |
| cpl_addr | output | AW | Completed line address |
| cpl_data | output | DW | Line data (dirty response or memory) |
| cpl_grant | output | 3 | Granted state code (R9) |
| cpl_flow | output | 2 | Flow used: 0 none, 1 directed, 2 multicast, 3 broadcast |

## Verification
A directed chain on one line grows its holder set step by step. This walks the flow choice from none through directed and multicast to broadcast. An exclusive request, a read of the resulting M line and a later read of the D line then separate the share probe from the invalidate probe and the O path from the migratory path. A second line mapped to the same directory slot tells victim eviction apart from a plain miss. Random requests from all agents to a few lines that collide on two slots mix every state and flow. In those requests the dirty response arrives at a random position among clean ones, which checks combining by count and the priority of dirty data. Completions are held back at random to expose payload changes under back-pressure.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0, LS_S = 3'd1, LS_F = 3'd2, LS_E = 3'd3,
    LS_O = 3'd4, LS_D = 3'd5, LS_M = 3'd6
  } line_st_e;

  typedef enum logic [1:0] {
    FL_NONE = 2'd0, FL_DIRECT = 2'd1, FL_MCAST = 2'd2, FL_BCAST = 2'd3
  } flow_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_VPRB, S_VCOL, S_MEM, S_PRB, S_WAIT, S_CPL
  } fsm_e;

  function automatic flow_e pick_flow(input int cnt, input int mmax);
    if (cnt == 0)         return FL_NONE;
    else if (cnt == 1)    return FL_DIRECT;
    else if (cnt <= mmax) return FL_MCAST;
    else                  return FL_BCAST;
  endfunction

endpackage

// File: rtl/pf_dir.sv
module pf_dir #(
  parameter int SETS = 16,
  parameter int TAGW = 12,
  parameter int NA   = 8,
  localparam int IDXW = $clog2(SETS),
  localparam int AGW  = $clog2(NA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDXW-1:0]  rd_idx,
  output logic             rd_v,
  output logic [TAGW-1:0]  rd_tag,
  output pf_pkg::line_st_e rd_st,
  output logic [AGW-1:0]   rd_own,
  output logic [NA-1:0]    rd_sh,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [TAGW-1:0]  wr_tag,
  input  pf_pkg::line_st_e wr_st,
  input  logic [AGW-1:0]   wr_own,
  input  logic [NA-1:0]    wr_sh
);
  logic             v_q   [SETS];
  logic [TAGW-1:0]  tag_q [SETS];
  pf_pkg::line_st_e st_q  [SETS];
  logic [AGW-1:0]   own_q [SETS];
  logic [NA-1:0]    sh_q  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDXW'(g)) begin
        v_q[g]   <= 1'b1;
        tag_q[g] <= wr_tag;
        st_q[g]  <= wr_st;
        own_q[g] <= wr_own;
        sh_q[g]  <= wr_sh;
      end
    end
  end

  assign rd_v   = v_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
  assign rd_st  = st_q[rd_idx];
  assign rd_own = own_q[rd_idx];
  assign rd_sh  = sh_q[rd_idx];
endmodule

// File: rtl/pf_policy.sv
module pf_policy #(
  parameter int NA        = 8,
  parameter int MCAST_MAX = 3,
  localparam int AGW  = $clog2(NA),
  localparam int CNTW = $clog2(NA + 1)
) (
  input  logic             hit,
  input  pf_pkg::line_st_e st,
  input  logic [AGW-1:0]   own,
  input  logic [NA-1:0]    sh,
  input  logic [AGW-1:0]   agent,
  input  logic             excl,
  output logic [NA-1:0]    mask,
  output pf_pkg::flow_e    flow,
  output logic             inval,
  output logic [CNTW-1:0]  need,
  output pf_pkg::line_st_e grant,
  output pf_pkg::line_st_e n_st,
  output logic [AGW-1:0]   n_own,
  output logic [NA-1:0]    n_sh
);
  import pf_pkg::*;
  logic [NA-1:0]   reqbit, holders, tgt;
  line_st_e        cur;
  logic [CNTW-1:0] tcnt;

  always_comb begin
    reqbit  = NA'(1) << agent;
    holders = hit ? sh : '0;
    cur     = hit ? st : LS_I;
    tgt     = holders & ~reqbit;
    tcnt    = CNTW'($countones(tgt));
    flow    = pick_flow(int'(tcnt), MCAST_MAX);
    mask    = (flow == FL_BCAST) ? ~reqbit : tgt;
    need    = CNTW'($countones(mask));
    inval   = 1'b0;
    n_own   = agent;
    n_sh    = holders | reqbit;
    if (excl) begin
      inval = 1'b1;
      grant = (cur inside {LS_M, LS_O, LS_D}) ? LS_D : LS_M;
      n_sh  = reqbit;
    end else begin
      case (cur)
        LS_I:       begin grant = LS_E; n_sh = reqbit; end
        LS_M, LS_O: begin grant = LS_S; n_own = own; end
        LS_D:       begin grant = LS_D; inval = 1'b1; n_sh = reqbit; end
        default:    grant = LS_F;
      endcase
    end
    n_st = excl ? grant : (grant == LS_S) ? LS_O : grant;
  end
endmodule

// File: rtl/pf_combine.sv
module pf_combine #(
  parameter int DW   = 32,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] need_in,
  input  logic            rsp_fire,
  input  logic            rsp_dirty,
  input  logic [DW-1:0]   rsp_data,
  input  logic            mem_fire,
  input  logic [DW-1:0]   mem_data,
  output logic            rsp_done,
  output logic            all_done,
  output logic [DW-1:0]   out_data
);
  logic [CNTW-1:0] need_q, got_q;
  logic            mem_got_q, dirty_got_q;
  logic [DW-1:0]   dirty_q, mem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q <= '0; got_q <= '0; mem_got_q <= 1'b0; dirty_got_q <= 1'b0;
    end else if (load) begin
      need_q <= need_in; got_q <= '0; mem_got_q <= 1'b0; dirty_got_q <= 1'b0;
    end else begin
      if (rsp_fire) begin
        got_q <= got_q + 1'b1;
        if (rsp_dirty) begin
          dirty_got_q <= 1'b1;
          dirty_q     <= rsp_data;
        end
      end
      if (mem_fire) begin
        mem_got_q <= 1'b1;
        mem_q     <= mem_data;
      end
    end
  end

  assign rsp_done = (got_q == need_q);
  assign all_done = rsp_done && mem_got_q;
  assign out_data = dirty_got_q ? dirty_q : mem_q;
endmodule

// File: rtl/pf_home.sv
module pf_home #(
  parameter int NA        = 8,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int SETS      = 16,
  parameter int MCAST_MAX = 3,
  localparam int AGW  = $clog2(NA),
  localparam int IDXW = $clog2(SETS),
  localparam int TAGW = AW - IDXW,
  localparam int CNTW = $clog2(NA + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [AGW-1:0] req_agent,
  input  logic           req_excl,
  output logic           prb_valid,
  input  logic           prb_ready,
  output logic [AW-1:0]  prb_addr,
  output logic [NA-1:0]  prb_mask,
  output logic           prb_inval,
  output logic [1:0]     prb_flow,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic           rsp_dirty,
  input  logic [DW-1:0]  rsp_data,
  output logic           mem_rd_valid,
  input  logic           mem_rd_ready,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           cpl_valid,
  input  logic           cpl_ready,
  output logic [AGW-1:0] cpl_agent,
  output logic [AW-1:0]  cpl_addr,
  output logic [DW-1:0]  cpl_data,
  output logic [2:0]     cpl_grant,
  output logic [1:0]     cpl_flow
);
  import pf_pkg::*;

  fsm_e           st_q;
  logic [AW-1:0]  r_addr;
  logic [AGW-1:0] r_agent;
  logic           r_excl;
  // registered directory read (lookup stage)
  logic           e_v;
  logic [TAGW-1:0] e_tag;
  line_st_e       e_st;
  logic [AGW-1:0] e_own;
  logic [NA-1:0]  e_sh;
  // dir array outputs
  logic           d_v;
  logic [TAGW-1:0] d_tag;
  line_st_e       d_st;
  logic [AGW-1:0] d_own;
  logic [NA-1:0]  d_sh;
  // chosen probe and result
  logic [NA-1:0]  p_mask;
  logic [AW-1:0]  p_addr;
  logic           p_inval;
  flow_e          p_flow;
  line_st_e       g_grant, n_st_q;
  logic [AGW-1:0] n_own_q;
  logic [NA-1:0]  n_sh_q;
  logic           mem_pend;

  logic [IDXW-1:0] r_idx;
  logic [TAGW-1:0] r_tag;
  logic            hit, victim;
  logic [CNTW-1:0] v_cnt, v_need, pol_need, need_sel;
  logic [NA-1:0]   v_mask, pol_mask, pol_nsh;
  flow_e           v_flow, pol_flow;
  logic            pol_inval;
  line_st_e        pol_grant, pol_nst;
  logic [AGW-1:0]  pol_nown;
  logic            rsp_done, all_done, rsp_fire, mem_fire;

  assign r_idx  = r_addr[IDXW-1:0];
  assign r_tag  = r_addr[AW-1:IDXW];
  assign hit    = e_v && (e_tag == r_tag);
  assign victim = e_v && !hit;
  assign v_cnt  = CNTW'($countones(e_sh));
  assign v_flow = pick_flow(int'(v_cnt), MCAST_MAX);
  assign v_mask = (v_flow == FL_BCAST) ? '1 : e_sh;
  assign v_need = CNTW'($countones(v_mask));
  assign need_sel = victim ? v_need : pol_need;

  pf_dir #(.SETS(SETS), .TAGW(TAGW), .NA(NA)) u_dir (
    .clk, .rst_n,
    .rd_idx (req_addr[IDXW-1:0]),
    .rd_v (d_v), .rd_tag (d_tag), .rd_st (d_st), .rd_own (d_own), .rd_sh (d_sh),
    .wr_en  (st_q == S_CPL && cpl_ready),
    .wr_idx (r_idx), .wr_tag (r_tag), .wr_st (n_st_q), .wr_own (n_own_q), .wr_sh (n_sh_q)
  );

  pf_policy #(.NA(NA), .MCAST_MAX(MCAST_MAX)) u_pol (
    .hit, .st (e_st), .own (e_own), .sh (e_sh), .agent (r_agent), .excl (r_excl),
    .mask (pol_mask), .flow (pol_flow), .inval (pol_inval), .need (pol_need),
    .grant (pol_grant), .n_st (pol_nst), .n_own (pol_nown), .n_sh (pol_nsh)
  );

  assign rsp_ready = (st_q == S_VCOL || st_q == S_WAIT) && !rsp_done;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign mem_rsp_ready = mem_pend;
  assign mem_fire  = mem_rsp_valid && mem_pend;

  pf_combine #(.DW(DW), .CNTW(CNTW)) u_cmb (
    .clk, .rst_n,
    .load (st_q == S_LOOK), .need_in (need_sel),
    .rsp_fire, .rsp_dirty, .rsp_data,
    .mem_fire, .mem_data (mem_rsp_data),
    .rsp_done, .all_done, .out_data (cpl_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; mem_pend <= 1'b0; e_v <= 1'b0;
    end else begin
      if (mem_fire) mem_pend <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          r_addr <= req_addr; r_agent <= req_agent; r_excl <= req_excl;
          e_v <= d_v; e_tag <= d_tag; e_st <= d_st; e_own <= d_own; e_sh <= d_sh;
          st_q <= S_LOOK;
        end
        S_LOOK: if (victim) begin
          p_mask <= v_mask; p_addr <= {e_tag, r_idx}; p_inval <= 1'b1; p_flow <= v_flow;
          st_q <= S_VPRB;
        end else begin
          p_mask <= pol_mask; p_addr <= r_addr; p_inval <= pol_inval; p_flow <= pol_flow;
          g_grant <= pol_grant; n_st_q <= pol_nst; n_own_q <= pol_nown; n_sh_q <= pol_nsh;
          st_q <= S_MEM;
        end
        S_VPRB: if (prb_ready) st_q <= S_VCOL;
        S_VCOL: if (rsp_done) begin e_v <= 1'b0; st_q <= S_LOOK; end
        S_MEM:  if (mem_rd_ready) begin
          mem_pend <= 1'b1;
          st_q <= (p_mask != '0) ? S_PRB : S_WAIT;
        end
        S_PRB:  if (prb_ready) st_q <= S_WAIT;
        S_WAIT: if (all_done) st_q <= S_CPL;
        S_CPL:  if (cpl_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st_q == S_IDLE);
  assign prb_valid    = (st_q == S_VPRB) || (st_q == S_PRB);
  assign prb_addr     = p_addr;
  assign prb_mask     = p_mask;
  assign prb_inval    = p_inval;
  assign prb_flow     = p_flow;
  assign mem_rd_valid = (st_q == S_MEM);
  assign mem_rd_addr  = r_addr;
  assign cpl_valid    = (st_q == S_CPL);
  assign cpl_agent    = r_agent;
  assign cpl_addr     = r_addr;
  assign cpl_grant    = g_grant;
  assign cpl_flow     = p_flow;
endmodule

// File: rtl/pf_home_checker.sv
module pf_home_checker #(
  parameter int NA        = 8,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int MCAST_MAX = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          prb_valid,
  input logic          prb_ready,
  input logic [NA-1:0] prb_mask,
  input logic [AW-1:0] prb_addr,
  input logic [1:0]    prb_flow,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          cpl_valid,
  input logic          cpl_ready,
  input logic [DW-1:0] cpl_data
);
  logic [7:0] owed;

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else owed <= owed
      + ((prb_valid && prb_ready) ? 8'($countones(prb_mask)) : 8'd0)
      - ((rsp_valid && rsp_ready) ? 8'd1 : 8'd0);
  end

  a_r7_cpl_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> owed == 8'd0);
  a_r7_no_extra_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |-> owed != 8'd0);
  a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r13_prb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && !prb_ready) |=> prb_valid && $stable(prb_mask) && $stable(prb_addr));
  a_r13_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> cpl_valid && $stable(cpl_data));
  a_r3_directed_one: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_flow == 2'd1) |-> $countones(prb_mask) == 1);
  a_r4_mcast_range: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_flow == 2'd2) |->
      ($countones(prb_mask) >= 2 && $countones(prb_mask) <= MCAST_MAX));
endmodule

bind pf_home pf_home_checker #(.NA(NA), .AW(AW), .DW(DW), .MCAST_MAX(MCAST_MAX)) u_chk (
  .clk, .rst_n, .req_valid, .req_ready, .prb_valid, .prb_ready, .prb_mask,
  .prb_addr, .prb_flow, .rsp_valid, .rsp_ready, .cpl_valid, .cpl_ready, .cpl_data
);

// File: tb/test_pf_home.sv
module test_pf_home;
  localparam int NA = 8, AW = 16, DW = 32, SETS = 16, MMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_excl = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_agent = '0;
  logic req_ready, prb_valid, prb_inval, rsp_ready, mem_rd_valid, mem_rsp_ready, cpl_valid;
  logic prb_ready = 0, rsp_valid = 0, rsp_dirty = 0, mem_rd_ready = 0, mem_rsp_valid = 0, cpl_ready = 0;
  logic [AW-1:0] prb_addr, mem_rd_addr, cpl_addr;
  logic [NA-1:0] prb_mask;
  logic [1:0] prb_flow, cpl_flow;
  logic [DW-1:0] rsp_data = '0, mem_rsp_data = '0, cpl_data;
  logic [2:0] cpl_agent, cpl_grant;

  always #10 clk = ~clk;

  pf_home #(.NA(NA), .AW(AW), .DW(DW), .SETS(SETS), .MCAST_MAX(MMAX)) i_pf_home (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference directory
  bit       m_v   [SETS];
  bit [11:0] m_tag [SETS];
  int       m_st  [SETS];
  int       m_own [SETS];
  bit [7:0] m_sh  [SETS];

  localparam int I_ = 0, S_ = 1, F_ = 2, E_ = 3, O_ = 4, D_ = 5, M_ = 6;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int popc(input bit [7:0] x);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(x[i]);
    return c;
  endfunction

  function automatic string flow_req(input int f);
    case (f)
      0: return "R2 no-probe";
      1: return "R3 directed";
      2: return "R4 multicast";
      default: return "R5 broadcast";
    endcase
  endfunction

  // send n responses; position dpos carries dirty data
  task automatic send_rsps(input int n, input int dpos, input bit [31:0] dd, input bit check_cpl);
    for (int i = 0; i < n; i++) begin
      if (check_cpl && i == n - 1)
        chk(cpl_valid == 1'b0, "R7 no completion before last response", cpl_valid, 0);
      rsp_valid = 1'b1;
      rsp_dirty = (i == dpos);
      rsp_data  = (i == dpos) ? dd : $urandom;
      while (!rsp_ready) @(negedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_dirty = 1'b0;
    end
  endtask

  task automatic run_txn(input int agent, input bit [15:0] addr, input bit excl);
    int idx = int'(addr[3:0]);
    bit [11:0] tag = addr[15:4];
    bit [7:0] reqbit = 8'(1) << agent;
    bit hit, dirty_own;
    bit [7:0] holders, tgt, emask, vmask;
    int cur, eflow, egrant, nst, nown, dpos;
    bit [7:0] nsh;
    bit einval;
    bit [31:0] mdata, ddata, exp_data;

    hit = m_v[idx] && (m_tag[idx] == tag);
    req_valid = 1'b1; req_addr = addr; req_agent = 3'(agent); req_excl = excl;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;

    if (m_v[idx] && !hit) begin
      vmask = (popc(m_sh[idx]) > MMAX) ? 8'hFF : m_sh[idx];
      while (!prb_valid) @(negedge clk);
      chk(prb_mask == vmask, "R11 victim mask", prb_mask, vmask);
      chk(prb_addr == {m_tag[idx], 4'(idx)}, "R11 victim address", prb_addr, {m_tag[idx], 4'(idx)});
      chk(prb_inval == 1'b1, "R11 victim invalidates", prb_inval, 1);
      prb_ready = 1'b1; @(negedge clk); prb_ready = 1'b0;
      dirty_own = (m_st[idx] inside {M_, O_, D_}) && vmask[m_own[idx]];
      send_rsps(popc(vmask), dirty_own ? int'($urandom % popc(vmask)) : -1, $urandom, 1'b0);
      m_v[idx] = 1'b0;
    end

    holders = hit ? m_sh[idx] : 8'h00;
    cur     = hit ? m_st[idx] : I_;
    tgt     = holders & ~reqbit;
    eflow   = (popc(tgt) == 0) ? 0 : (popc(tgt) == 1) ? 1 : (popc(tgt) <= MMAX) ? 2 : 3;
    emask   = (eflow == 3) ? ~reqbit : tgt;
    nown = agent; nsh = holders | reqbit; einval = 1'b0;
    if (excl) begin
      einval = 1'b1; egrant = (cur inside {M_, O_, D_}) ? D_ : M_; nst = egrant; nsh = reqbit;
    end else if (cur == I_) begin
      egrant = E_; nst = E_; nsh = reqbit;
    end else if (cur == M_ || cur == O_) begin
      egrant = S_; nst = O_; nown = m_own[idx];
    end else if (cur == D_) begin
      einval = 1'b1; egrant = D_; nst = D_; nsh = reqbit;
    end else begin
      egrant = F_; nst = F_;
    end

    while (!mem_rd_valid) @(negedge clk);
    chk(req_ready == 1'b0, "R12 request blocked while busy", req_ready, 0);
    chk(mem_rd_addr == addr, "R2 memory read address", mem_rd_addr, addr);
    mem_rd_ready = 1'b1; @(negedge clk); mem_rd_ready = 1'b0;
    mdata = $urandom;
    mem_rsp_valid = 1'b1; mem_rsp_data = mdata;
    while (!mem_rsp_ready) @(negedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0;

    exp_data = mdata;
    if (emask != 8'h00) begin
      while (!prb_valid) @(negedge clk);
      chk(prb_mask == emask, flow_req(eflow), prb_mask, emask);
      chk(prb_flow == 2'(eflow), flow_req(eflow), prb_flow, eflow);
      chk(prb_inval == einval, "R6 probe kind", prb_inval, einval);
      if (!excl && cur == D_) chk(prb_inval == 1'b1, "R10 migratory invalidate", prb_inval, 1);
      prb_ready = 1'b0; @(negedge clk);
      chk(prb_valid && prb_mask == emask, "R13 probe held", prb_mask, emask);
      prb_ready = 1'b1; @(negedge clk); prb_ready = 1'b0;
      dirty_own = hit && (cur inside {M_, O_, D_}) && emask[m_own[idx]];
      ddata = $urandom;
      dpos = dirty_own ? int'($urandom % popc(emask)) : -1;
      if (dirty_own) exp_data = ddata;
      send_rsps(popc(emask), dpos, ddata, 1'b1);
    end

    while (!cpl_valid) begin
      if (emask == 8'h00) chk(prb_valid == 1'b0, "R2 no probe sent", prb_valid, 0);
      @(negedge clk);
    end
    if ($urandom % 2 == 1) begin
      repeat (2) @(negedge clk);
      chk(cpl_valid && cpl_data == exp_data, "R13 completion held", cpl_data, exp_data);
    end
    chk(cpl_data == exp_data, (exp_data != mdata) ? "R8 dirty data wins" : "R7 memory data",
        cpl_data, exp_data);
    chk(cpl_grant == 3'(egrant), "R9 grant state", cpl_grant, egrant);
    chk(cpl_flow == 2'(eflow), flow_req(eflow), cpl_flow, eflow);
    chk(cpl_agent == 3'(agent) && cpl_addr == addr, "R7 completion target", cpl_agent, agent);
    cpl_ready = 1'b1; @(negedge clk); cpl_ready = 1'b0;
    chk(cpl_valid == 1'b0, "R7 single completion", cpl_valid, 0);

    m_v[idx] = 1'b1; m_tag[idx] = tag; m_st[idx] = nst; m_own[idx] = nown; m_sh[idx] = nsh;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < SETS; s++) m_v[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(!prb_valid && !mem_rd_valid && !cpl_valid, "R1 reset idle outputs",
        {prb_valid, mem_rd_valid, cpl_valid}, 0);

    // directed chain on one line
    run_txn(0, 16'h0010, 0);  // R2 untracked, grant E
    run_txn(1, 16'h0010, 0);  // R3 directed share, grant F
    run_txn(2, 16'h0010, 0);  // R4 multicast
    run_txn(3, 16'h0010, 0);  // R4 multicast of three
    run_txn(4, 16'h0010, 0);  // R5 broadcast
    run_txn(5, 16'h0010, 1);  // R5/R6 broadcast invalidate, grant M
    run_txn(6, 16'h0010, 0);  // R8 dirty share, grant S, line O
    run_txn(7, 16'h0010, 1);  // R6 invalidate from O, grant D
    run_txn(0, 16'h0010, 0);  // R10 migratory read of D
    run_txn(1, 16'h0010, 0);  // R10 only agent 0 probed
    run_txn(2, 16'h0110, 0);  // R11 victim eviction then untracked

    for (int k = 0; k < 150; k++) begin
      bit [15:0] a = {8'h00, 4'($urandom_range(0, 2)), 4'($urandom_range(0, 1))};
      run_txn(int'($urandom % 8), a, ($urandom % 4) == 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule